// File: doc/BRIEF.md
# Interpolating Sigma-Delta Bitstream Modulator

This block turns a slow stream of signed 10-bit words into a one-bit stream at the full clock rate. A new word arrives with a one-cycle load strobe, nominally once every ten clocks. The block keeps that word and feeds it to a third-order loop filter on every clock until the next strobe. The long-run density of ones in the output then follows the word's value.

The loop filter is three integrators in a chain. On every clock, each integrator adds three terms: its own state, an input term and the negated quantiser feedback. The first integrator's input term is the held word. Each later integrator takes the previous integrator's registered state, scaled down by an arithmetic right shift. This means no adder waits on another adder within a cycle. The states saturate at the 16-bit signed limits. The output bit is registered and equals the sign of the last integrator: 1 when that integrator is non-negative.

Top module: `sd_bitstream_mod`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a clock edge, all integrator states and the held word are cleared and the output bit becomes 0. The output bit stays 0 until the first edge with reset low.
- R2: A word is captured only at a clock edge where the strobe is 1. The word is read as two's complement (bit 9 is the sign). At edges with the strobe at 0, the word input has no effect on the output stream.
- R3: Exactly one output bit is produced per clock. After each edge, the output is 1 if and only if the last integrator's new state is zero or positive.
- R4: The feedback term is +512 when the current output bit is 1 and -512 when it is 0. It is subtracted in all three integrators at every edge.
- R5: With states s0, s1, s2 and held word h, each edge computes: s0 gets s0 + h - fb, s1 gets s1 + (s0 >>> 3) - fb, s2 gets s2 + (s1 >>> 2) - fb. All right-hand values are from before the edge, and the shifts are arithmetic.
- R6: Each integrator result is clamped to the range -32768 to +32767 and never wraps.
- R7: Take a constant input u in the range -200 to +200, strobed every ten clocks, and let the loop settle. Over any 4000-clock window, the count of ones is within 66 of 4000*(u+512)/1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_strobe | input | 1 | Load strobe for a new sample word |
| smp_word | input | 10 | Signed sample word |
| bit_out | output | 1 | Modulated one-bit stream |

## Verification
The checks on the first integrator's exact step assume its state starts at least two full-scale steps away from either rail. The checks on each integrator's step size assume the held word stays within ±512. The DC tracking bound holds only while the first integrator does not clip, which requires a stable loop. The stimulus therefore keeps DC levels at or below about 0.4 of full scale. Near-full-scale inputs are used only in a separate overload phase, where the bench compares against its cycle model and applies no density bound. Words presented without a strobe are driven with changing junk values, so that any leak into the held word would show up in the bit stream.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    localparam int IN_W      = 10;
    localparam int ACC_W     = 16;
    localparam int N_STAGES  = 3;
    localparam int SHIFT_MID = 3;
    localparam int SHIFT_END = 2;

    localparam int FS     = 1 << (IN_W - 1);
    localparam int ACC_HI = (1 << (ACC_W - 1)) - 1;
    localparam int ACC_LO = -(1 << (ACC_W - 1));

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [ACC_W+1:0] wide_t;

    localparam acc_t FB_POS = acc_t'(FS);
    localparam acc_t FB_NEG = acc_t'(-FS);

    // right shift applied to the addend of stage k
    function automatic int stage_shift(int k);
        if (k == 0) return 0;
        return (k == N_STAGES - 1) ? SHIFT_END : SHIFT_MID;
    endfunction

    // state + addend - feedback, clamped to the accumulator range
    function automatic acc_t sat_acc(acc_t st, acc_t add, acc_t fb);
        wide_t sum;
        sum = wide_t'(st) + wide_t'(add) - wide_t'(fb);
        if (sum > wide_t'(ACC_HI)) return acc_t'(ACC_HI);
        if (sum < wide_t'(ACC_LO)) return acc_t'(ACC_LO);
        return sum[ACC_W-1:0];
    endfunction
endpackage

// File: rtl/sdm_word_hold.sv
module sdm_word_hold
    import sdm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [IN_W-1:0] word_i,
    output acc_t            held_o
);
    logic signed [IN_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= word_i;
        end
    end

    assign held_o = acc_t'(word_q);
endmodule

// File: rtl/sdm_integ_stage.sv
module sdm_integ_stage
    import sdm_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  acc_t state_i,
    input  acc_t addend_i,
    input  acc_t fb_i,
    output acc_t next_o
);
    acc_t scaled;

    assign scaled = addend_i >>> SHIFT;
    assign next_o = sat_acc(state_i, scaled, fb_i);
endmodule

// File: rtl/sdm_sign_slicer.sv
module sdm_sign_slicer
    import sdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t last_next_i,
    output logic bit_o,
    output acc_t fb_o
);
    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= (last_next_i >= 0);
        end
    end

    assign bit_o = bit_q;
    assign fb_o  = bit_q ? FB_POS : FB_NEG;
endmodule

// File: rtl/sd_bitstream_mod.sv
module sd_bitstream_mod
    import sdm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_strobe,
    input  logic [IN_W-1:0] smp_word,
    output logic            bit_out
);
    acc_t                  held;
    acc_t                  fb;
    acc_t [N_STAGES-1:0]   st_q;
    acc_t [N_STAGES-1:0]   st_nx;

    sdm_word_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (smp_strobe),
        .word_i (smp_word),
        .held_o (held)
    );

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        acc_t addend;
        if (k == 0) begin : g_head
            assign addend = held;
        end else begin : g_tail
            assign addend = st_q[k-1];
        end

        sdm_integ_stage #(.SHIFT(stage_shift(k))) u_integ (
            .state_i  (st_q[k]),
            .addend_i (addend),
            .fb_i     (fb),
            .next_o   (st_nx[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_nx;
        end
    end

    sdm_sign_slicer u_slice (
        .clk         (clk),
        .rst         (rst),
        .last_next_i (st_nx[N_STAGES-1]),
        .bit_o       (bit_out),
        .fb_o        (fb)
    );
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker
    import sdm_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                strobe,
    input acc_t                held,
    input acc_t [N_STAGES-1:0] st_q,
    input logic                bit_out
);
    // armed: the previous edge was taken out of reset
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (bit_out == 1'b0 && st_q == '0));

    p_hold_word_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(strobe)) |-> (held == $past(held)));

    p_sign_out_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> (bit_out == (st_q[N_STAGES-1] >= 0)));

    p_fb_step_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && int'($past(st_q[0])) < ACC_HI - 2*FS
               && int'($past(st_q[0])) > ACC_LO + 2*FS)
        |-> (int'(st_q[0]) == int'($past(st_q[0])) + int'($past(held))
                              - ($past(bit_out) ? FS : -FS)));

    for (genvar k = 0; k < N_STAGES; k++) begin : g_wrap
        localparam int LIM = (k == 0) ? 2*FS
                           : ((1 << (ACC_W-1)) >> stage_shift(k)) + FS;
        p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
            armed |-> ((int'(st_q[k]) - int'($past(st_q[k])) <= LIM) &&
                       (int'($past(st_q[k])) - int'(st_q[k]) <= LIM)));
    end
endmodule

bind sd_bitstream_mod sdm_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .strobe  (smp_strobe),
    .held    (held),
    .st_q    (st_q),
    .bit_out (bit_out)
);

// File: tb/sd_bitstream_mod_test.sv
module sd_bitstream_mod_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 10;          // 50 MHz
    localparam int WDOG = 200000;
    localparam int RAIL_HI = 32767;
    localparam int RAIL_LO = -32768;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_strobe = 1'b0;
    logic [9:0] smp_word = '0;
    logic       bit_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // behavioural reference state
    int m_s0 = 0, m_s1 = 0, m_s2 = 0, m_held = 0;
    bit m_bit = 1'b0;

    sd_bitstream_mod uut (
        .clk        (clk),
        .rst        (rst),
        .smp_strobe (smp_strobe),
        .smp_word   (smp_word),
        .bit_out    (bit_out)
    );

    always #HALF clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int clampv(int v);
        if (v > RAIL_HI) return RAIL_HI;
        if (v < RAIL_LO) return RAIL_LO;
        return v;
    endfunction

    task automatic model_edge(bit r, bit stb, int val);
        int f, a, b, c;
        if (r) begin
            m_s0 = 0; m_s1 = 0; m_s2 = 0; m_held = 0; m_bit = 1'b0;
            return;
        end
        f = m_bit ? 512 : -512;
        a = clampv(m_s0 + m_held - f);
        b = clampv(m_s1 + (m_s0 >>> 3) - f);
        c = clampv(m_s2 + (m_s1 >>> 2) - f);
        m_s0 = a; m_s1 = b; m_s2 = c;
        m_bit = (c >= 0);
        if (stb) m_held = val;
    endtask

    // drive one clock from a falling edge, compare at the next falling edge
    task automatic step(bit stb, int val, string tag);
        smp_strobe = stb;
        smp_word   = stb ? 10'(val) : 10'((cyc * 37 + 5) & 1023);
        model_edge(rst, stb, val);
        @(posedge clk);
        @(negedge clk);
        cyc++;
        chk(bit_out == m_bit, tag, int'(bit_out), int'(m_bit));
    endtask

    task automatic dc_run(int u, int settle, int win);
        int ones = 0;
        int expd;
        int diff;
        for (int i = 0; i < settle + win; i++) begin
            step((i % 10) == 0, u, "R3/R4/R5 bit vs model");
            if (i >= settle) ones += int'(bit_out);
        end
        expd = (win * (u + 512)) / 1024;
        diff = ones - expd;
        chk(diff <= 66 && diff >= -66, "R7 ones density", ones, expd);
    endtask

    initial begin
        #(2 * HALF * WDOG);
        n_err++;
        n_chk++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, WDOG);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state, junk on inputs during reset
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 300 - i, "R1 reset output");
            chk(bit_out == 1'b0, "R1 output low in reset", int'(bit_out), 0);
        end
        rst = 1'b0;

        // DC tracking at several levels
        dc_run(0,    1000, 4000);
        dc_run(137,  1000, 4000);
        dc_run(-200, 1000, 4000);
        dc_run(64,   1000, 4000);

        // R2: staircase of words with junk between strobes
        for (int i = 0; i < 3000; i++) begin
            step((i % 10) == 0, ((i / 10) * 53) % 400 - 200, "R2 strobe-only capture");
        end

        // R2: irregular strobe spacing, word changes without strobe
        for (int i = 0; i < 1000; i++) begin
            step((i % 23) == 0 || (i % 7) == 3, (i * 11) % 300 - 150, "R2 irregular strobes");
        end

        // R6: overload towards both rails
        for (int i = 0; i < 3000; i++) step((i % 10) == 0, 511, "R6 clamp high overload");
        for (int i = 0; i < 3000; i++) step((i % 10) == 0, -512, "R6 clamp low overload");
        for (int i = 0; i < 1000; i++) step((i % 10) == 0, 0, "R6 recovery");

        // R1: reset in mid-stream
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 0, "R1 mid reset");
            chk(bit_out == 1'b0, "R1 output low after mid reset", int'(bit_out), 0);
        end
        rst = 1'b0;
        step(1'b1, -100, "R1 first bit after reset");
        chk(bit_out == 1'b1, "R1 first edge out of reset", int'(bit_out), 1);
        dc_run(-100, 1000, 4000);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule